// File: doc/BRIEF.md
# NAND Bank Select and Command/Address Bridge

This block connects a simple request/acknowledge host bus to up to four external NAND flash banks. The host sees two regions. The register region holds a control register and a status register. The bank-window region turns every host access into one NAND bus cycle. Inside a window, the offset of the access picks the cycle type: a command byte (CLE high), an address byte (ALE high) or a data byte. Each bank's active-low chip enable comes from two bits in the control register. One bit enables the bank and a separate bit asserts its chip select. The bits sit in interleaved pairs, so software can drop every chip select with one mask and leave the enables alone.

Every NAND cycle runs through a small strobe engine with fixed phases. There is one setup clock, then a write or read strobe held low for `STB_CLKS` clocks, then one hold clock. The host is held off until the cycle ends. The NAND ready/busy pin passes through a two-flop synchroniser and can be read in the status register. The data bus is split into an output byte, an output enable and an input byte, so the pad ring can build the tri-state driver.

Host address layout, with the default `ADDR_W = 20`:
- Bit 19 selects the region: 1 is the register region and 0 is a bank window.
- In a bank window, bits 18:17 name the bank and bits 16:0 are the offset. The bank field is not decoded. Whichever chip enables are active receive the cycle.
- In the register region, bit 2 picks the register: 0 is the control register and 1 is the status register.

Top module: `nand_bank_bridge`

## Requirements
- R1: After reset, the outputs sit at their idle values, `hst_ack` is low, and a read of the control register returns 0:
  - every `nd_ce_n` bit is high;
  - `nd_we_n` and `nd_re_n` are high;
  - `nd_cle`, `nd_ale` and `nd_doe` are low.
- R2: Control register layout, one pair of bits per bank n (0..NUM_BANKS-1):
  - bit 2n is the bank enable and bit 2n+1 is the chip-assert bit;
  - a register-region write with address bit 2 = 0 loads bits [2*NUM_BANKS-1:0] from `hst_wdata`;
  - a read at the same address returns them, zero-extended.
- R3: `nd_ce_n[n]` is low exactly when both bit 2n and bit 2n+1 of the control register are 1. It changes in the cycle after the write is accepted.
- R4: Writing the control register with the odd bits cleared (the current value ANDed with the inverse of 0xAA for four banks) raises every chip enable and keeps the enable bits, as a readback shows. Writing 0 disables and deasserts every bank.
- R5: Offset decode in a bank window:
  - offset bit 16 set (offset 0x10000) makes an address cycle with `nd_ale` high;
  - offset bit 15 set (offset 0x08000) makes a command cycle with `nd_cle` high;
  - with neither bit set, the write is a data cycle with both low;
  - the other offset bits do not matter.
- R6: A window access with both offset bits 16 and 15 set runs no NAND cycle. No strobe fires and neither CLE nor ALE rises. It is acknowledged one cycle after acceptance with `hst_err` = 1.
- R7: A window write accepted at clock edge k produces this sequence:
  - for one setup clock, `nd_we_n` is high while `nd_doe`, `nd_dout`, `nd_cle` and `nd_ale` carry the cycle;
  - `nd_we_n` is then low for exactly `STB_CLKS` clocks;
  - one hold clock follows with the same values and `nd_we_n` high;
  - `hst_ack` is high for the next single clock, with `hst_err` = 0.
- R8: A data-window read (offset bits 16 and 15 both 0) follows the same timing with `nd_re_n` as the strobe and `nd_doe` low.
  - `nd_din` is captured at the clock edge that ends the last strobe clock.
  - It is returned as `hst_rdata[7:0]` with the upper bits zero.
  - A read with offset bit 16 or bit 15 set is answered as in R6.
- R9: The status register (register region, address bit 2 = 1) returns `nd_rb` in bit 0, delayed by two clock edges through the synchroniser. Writes to it change nothing.
- R10: One access at a time. No new request is accepted while a NAND cycle or an acknowledge is in progress, and `hst_ack` is a single-clock pulse.
- R11: A register-region access is acknowledged one clock after acceptance with `hst_err` = 0.
- R12: `nd_cle` and `nd_ale` are never high together, and `nd_we_n` and `nd_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hst_req | input | 1 | Host request; held with address and data until `hst_ack` is seen |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Host address (region, bank window, offset / register select) |
| hst_wdata | input | DATA_W | Write data (low byte drives NAND data, low 2*NUM_BANKS bits load control) |
| hst_rdata | output | DATA_W | Read data, valid with `hst_ack` on reads |
| hst_ack | output | 1 | One-clock completion pulse |
| hst_err | output | 1 | Access refused, valid with `hst_ack` |
| nd_ce_n | output | NUM_BANKS | Per-bank active-low chip enable |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Active-low write strobe |
| nd_re_n | output | 1 | Active-low read strobe |
| nd_dout | output | 8 | NAND data bus, outbound byte |
| nd_doe | output | 1 | Output enable for `nd_dout` |
| nd_din | input | 8 | NAND data bus, inbound byte |
| nd_rb | input | 1 | NAND ready (1) / busy (0), asynchronous |

## Verification
A wrong strobe-engine state shows up at the NAND pins within one clock:
- a skipped setup or hold clock moves the `nd_we_n` or `nd_re_n` edge against CLE, ALE and data;
- a miscounted strobe stretches or shortens the low pulse;
- in both cases the acknowledge moves in time.

A corrupt control register shows on `nd_ce_n` in the clock after the write, and on the next control readback. A capture in the wrong clock returns the wrong byte with the acknowledge of that same read. A missing synchroniser stage shows as status returning the new ready level one access early.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  localparam int unsigned NAND_BYTE_W = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SETUP = 2'd1,
    ENG_STRB  = 2'd2,
    ENG_HOLD  = 2'd3
  } eng_state_e;

endpackage

// File: rtl/nbb_sync2.sv
module nbb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

  // R9
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_sync) |-> $past(d_async, 2));

endmodule

// File: rtl/nbb_ctrl_reg.sv
module nbb_ctrl_reg #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned CTRL_W   = 2 * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_val,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NUM_BANKS-1:0] ce_n
);

  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] ctrl_r;

  always_comb begin
    ctrl_d = ctrl_r;
    if (wr_en) ctrl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_r <= '0;
    else        ctrl_r <= ctrl_d;
  end

  assign ctrl_q = ctrl_r;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_ce
    assign ce_n[b] = ~(ctrl_r[2*b] & ctrl_r[2*b+1]);
  end

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

  // R4
  ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val == '0) |=> (&ce_n));

endmodule

// File: rtl/nbb_strobe_engine.sv
module nbb_strobe_engine
  import nbb_pkg::*;
#(
  parameter int unsigned STB_CLKS = 3,
  localparam int unsigned CNT_W   = (STB_CLKS < 2) ? 1 : $clog2(STB_CLKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   op_rd,
  input  logic                   op_cle,
  input  logic                   op_ale,
  input  logic [NAND_BYTE_W-1:0] op_data,
  input  logic [NAND_BYTE_W-1:0] nd_din,
  output logic                   nd_we_n,
  output logic                   nd_re_n,
  output logic                   nd_cle,
  output logic                   nd_ale,
  output logic [NAND_BYTE_W-1:0] nd_dout,
  output logic                   nd_doe,
  output logic                   busy,
  output logic                   done,
  output logic                   done_rd,
  output logic [NAND_BYTE_W-1:0] rd_byte
);

  eng_state_e             st_q, st_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   rd_q, cle_q, ale_q;
  logic [NAND_BYTE_W-1:0] dat_q, cap_q, cap_d;
  logic                   load_en;
  logic                   last_stb;

  assign load_en  = start && (st_q == ENG_IDLE);
  assign last_stb = (cnt_q == CNT_W'(STB_CLKS - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cap_d = cap_q;
    case (st_q)
      ENG_IDLE:  if (start) st_d = ENG_SETUP;
      ENG_SETUP: begin
        st_d  = ENG_STRB;
        cnt_d = '0;
      end
      ENG_STRB: begin
        if (last_stb) begin
          st_d = ENG_HOLD;
          if (rd_q) cap_d = nd_din;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ENG_HOLD:  st_d = ENG_IDLE;
      default:   st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      cle_q <= 1'b0;
      ale_q <= 1'b0;
      dat_q <= '0;
    end else if (load_en) begin
      rd_q  <= op_rd;
      cle_q <= op_cle;
      ale_q <= op_ale;
      dat_q <= op_data;
    end
  end

  assign busy    = (st_q != ENG_IDLE);
  assign done    = (st_q == ENG_HOLD);
  assign done_rd = done && rd_q;
  assign rd_byte = cap_q;
  assign nd_cle  = busy && cle_q;
  assign nd_ale  = busy && ale_q;
  assign nd_doe  = busy && !rd_q;
  assign nd_dout = dat_q;
  assign nd_we_n = !((st_q == ENG_STRB) && !rd_q);
  assign nd_re_n = !((st_q == ENG_STRB) && rd_q);

  logic [15:0] lo_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lo_len_q <= '0;
    else if (!nd_we_n || !nd_re_n) lo_len_q <= lo_len_q + 16'd1;
    else                        lo_len_q <= '0;
  end

  // R7
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nd_we_n) |-> ($stable(nd_dout) && $stable(nd_cle) && $stable(nd_ale) && nd_doe));

  // R7
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nd_we_n) |-> ($stable(nd_dout) && $stable(nd_cle) && $stable(nd_ale) && nd_doe));

  // R7
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nd_we_n) |-> (lo_len_q == 16'(STB_CLKS)));

  // R8
  re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nd_re_n) |-> (lo_len_q == 16'(STB_CLKS) && !nd_doe));

endmodule

// File: rtl/nand_bank_bridge.sv
module nand_bank_bridge
  import nbb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned STB_CLKS  = 3,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ALE_BIT   = 16,
  parameter int unsigned CLE_BIT   = 15,
  localparam int unsigned CTRL_W   = 2 * NUM_BANKS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hst_req,
  input  logic                   hst_wr,
  input  logic [ADDR_W-1:0]      hst_addr,
  input  logic [DATA_W-1:0]      hst_wdata,
  output logic [DATA_W-1:0]      hst_rdata,
  output logic                   hst_ack,
  output logic                   hst_err,
  output logic [NUM_BANKS-1:0]   nd_ce_n,
  output logic                   nd_cle,
  output logic                   nd_ale,
  output logic                   nd_we_n,
  output logic                   nd_re_n,
  output logic [NAND_BYTE_W-1:0] nd_dout,
  output logic                   nd_doe,
  input  logic [NAND_BYTE_W-1:0] nd_din,
  input  logic                   nd_rb
);

  localparam int unsigned REG_BIT = ADDR_W - 1;

  logic                   ack_q, ack_d, err_q, err_d;
  logic [DATA_W-1:0]      rdata_q, rdata_d;
  logic                   eng_busy, eng_done, eng_done_rd;
  logic [NAND_BYTE_W-1:0] eng_rd_byte;
  logic [CTRL_W-1:0]      ctrl_q;
  logic                   rb_sync;
  logic                   accept, in_win, off_ale, off_cle, off_both;
  logic                   nand_go, bad_go, reg_go, ctrl_wr, stat_sel;

  assign off_ale  = hst_addr[ALE_BIT];
  assign off_cle  = hst_addr[CLE_BIT];
  assign off_both = off_ale && off_cle;
  assign in_win   = !hst_addr[REG_BIT];
  assign stat_sel = hst_addr[2];
  assign accept   = hst_req && !ack_q && !eng_busy;
  assign nand_go  = accept && in_win && !off_both && (hst_wr || (!off_ale && !off_cle));
  assign bad_go   = accept && in_win && !nand_go;
  assign reg_go   = accept && !in_win;
  assign ctrl_wr  = reg_go && hst_wr && !stat_sel;

  logic unused_ok;
  assign unused_ok = ^{hst_addr[REG_BIT-1:ALE_BIT+1], hst_addr[CLE_BIT-1:3],
                       hst_addr[1:0], hst_wdata[DATA_W-1:CTRL_W]};

  nbb_ctrl_reg #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wr_val (hst_wdata[CTRL_W-1:0]),
    .ctrl_q (ctrl_q),
    .ce_n   (nd_ce_n)
  );

  nbb_sync2 u_rb_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (nd_rb),
    .q_sync  (rb_sync)
  );

  nbb_strobe_engine #(.STB_CLKS(STB_CLKS)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (nand_go),
    .op_rd   (!hst_wr),
    .op_cle  (off_cle),
    .op_ale  (off_ale),
    .op_data (hst_wdata[NAND_BYTE_W-1:0]),
    .nd_din  (nd_din),
    .nd_we_n (nd_we_n),
    .nd_re_n (nd_re_n),
    .nd_cle  (nd_cle),
    .nd_ale  (nd_ale),
    .nd_dout (nd_dout),
    .nd_doe  (nd_doe),
    .busy    (eng_busy),
    .done    (eng_done),
    .done_rd (eng_done_rd),
    .rd_byte (eng_rd_byte)
  );

  always_comb begin
    ack_d   = reg_go || bad_go || eng_done;
    err_d   = bad_go;
    rdata_d = rdata_q;
    if (reg_go && !hst_wr) begin
      if (stat_sel) rdata_d = {{(DATA_W-1){1'b0}}, rb_sync};
      else          rdata_d = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    end else if (eng_done_rd) begin
      rdata_d = {{(DATA_W-NAND_BYTE_W){1'b0}}, eng_rd_byte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= ack_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign hst_ack   = ack_q;
  assign hst_err   = err_q;
  assign hst_rdata = rdata_q;

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |=> !hst_ack);

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_we_n == 1'b0 || nd_re_n == 1'b0) |-> !hst_ack);

  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nd_cle && nd_ale));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_we_n || nd_re_n));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_err |-> (nd_we_n && nd_re_n && !nd_cle && !nd_ale));

endmodule

// File: tb/nand_bank_bridge_bench.sv
`timescale 1ns/1ps
module nand_bank_bridge_bench;

  localparam int NB = 4;
  localparam int S  = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_req, hst_wr;
  logic [19:0] hst_addr;
  logic [31:0] hst_wdata, hst_rdata;
  logic        hst_ack, hst_err;
  logic [NB-1:0] nd_ce_n;
  logic        nd_cle, nd_ale, nd_we_n, nd_re_n, nd_doe, nd_rb;
  logic [7:0]  nd_dout, nd_din;

  always #2.5 clk = ~clk;

  nand_bank_bridge #(.NUM_BANKS(NB), .STB_CLKS(S)) u_nand_bank_bridge (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_ack(hst_ack), .hst_err(hst_err), .nd_ce_n(nd_ce_n),
    .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
    .nd_dout(nd_dout), .nd_doe(nd_doe), .nd_din(nd_din), .nd_rb(nd_rb)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // expected values for the current cycle
  logic       e_we, e_re, e_cle, e_ale, e_doe, e_ack, e_err, e_chk;
  logic [7:0] e_dout;
  logic [31:0] e_rd;
  int         ctrl_m;

  function automatic logic [NB-1:0] model_ce(input int c);
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = !(c[2*b] && c[2*b+1]);
    return r;
  endfunction

  task automatic exp_idle();
    e_we = 1; e_re = 1; e_cle = 0; e_ale = 0; e_doe = 0; e_dout = 0;
    e_ack = 0; e_err = 0; e_chk = 0; e_rd = 0;
  endtask

  task automatic step(input string tag);
    logic ok;
    logic [NB-1:0] ce_e;
    @(negedge clk);
    ce_e = model_ce(ctrl_m);
    ok = (nd_we_n === e_we) && (nd_re_n === e_re) && (nd_cle === e_cle) &&
         (nd_ale === e_ale) && (nd_doe === e_doe) && (hst_ack === e_ack) &&
         (nd_ce_n === ce_e) && (!e_doe || nd_dout === e_dout) &&
         (!e_ack || hst_err === e_err) && (!e_chk || hst_rdata === e_rd);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act we=%b re=%b cle=%b ale=%b oe=%b do=%h ack=%b err=%b rd=%h ce=%b exp we=%b re=%b cle=%b ale=%b oe=%b do=%h ack=%b err=%b rd=%h ce=%b",
               tag, nd_we_n, nd_re_n, nd_cle, nd_ale, nd_doe, nd_dout, hst_ack, hst_err, hst_rdata, nd_ce_n,
               e_we, e_re, e_cle, e_ale, e_doe, e_dout, e_ack, e_err, e_rd, ce_e);
    end
  endtask

  task automatic finish_req(input string tag);
    hst_req = 0;
    exp_idle();
    step(tag);
  endtask

  // register-region access or refused window access: ack one clock later
  task automatic short_acc(input logic wr, input logic [19:0] a, input logic [31:0] wd,
                           input logic chk, input logic [31:0] rd, input logic err,
                           input logic upd, input string tag);
    hst_req = 1; hst_wr = wr; hst_addr = a; hst_wdata = wd;
    exp_idle();
    if (upd) ctrl_m = int'(wd[7:0]);
    e_ack = 1; e_err = err; e_chk = chk; e_rd = rd;
    step(tag);
    finish_req(tag);
  endtask

  task automatic nand_write(input logic [19:0] a, input logic [7:0] d,
                            input logic cl, input logic al, input string tag);
    hst_req = 1; hst_wr = 1; hst_addr = a; hst_wdata = {24'hFFFFFF, d};
    exp_idle(); e_cle = cl; e_ale = al; e_doe = 1; e_dout = d;
    step(tag);                         // setup clock
    e_we = 0;
    for (int i = 0; i < S; i++) step(tag);
    e_we = 1;
    step(tag);                         // hold clock
    exp_idle(); e_ack = 1; e_err = 0;
    step(tag);
    finish_req(tag);
  endtask

  task automatic nand_read(input logic [19:0] a, input logic [7:0] early,
                           input logic [7:0] late, input string tag);
    hst_req = 1; hst_wr = 0; hst_addr = a; hst_wdata = 0; nd_din = early;
    exp_idle();
    step(tag);
    e_re = 0;
    for (int i = 0; i < S; i++) begin
      step(tag);
      if (i == S - 1) nd_din = late;
    end
    e_re = 1;
    step(tag);
    nd_din = early;
    e_ack = 1; e_err = 0; e_chk = 1; e_rd = {24'h0, late};
    step(tag);
    finish_req(tag);
  endtask

  localparam logic [19:0] REG_CTRL = 20'h80000;
  localparam logic [19:0] REG_STAT = 20'h80004;

  initial begin
    #200000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hst_req = 0; hst_wr = 0; hst_addr = 0; hst_wdata = 0;
    nd_din = 0; nd_rb = 0; ctrl_m = 0;
    exp_idle();
    step("R1 in reset");
    step("R1 in reset");
    rst_n = 1;
    step("R1 after reset");
    short_acc(0, REG_CTRL, 0, 1, 32'h0, 0, 0, "R1 ctrl reads zero");

    // R3: enable alone does not assert chip enable
    short_acc(1, REG_CTRL, 32'h01, 0, 0, 0, 1, "R3 enable only");
    short_acc(1, REG_CTRL, 32'h08, 0, 0, 0, 1, "R3 assert only");
    short_acc(1, REG_CTRL, 32'h03, 0, 0, 0, 1, "R3 bank0 both bits");
    short_acc(1, REG_CTRL, 32'h0C, 0, 0, 0, 1, "R2 bank1 pair position");
    short_acc(1, REG_CTRL, 32'hFFFF_FFFF, 0, 0, 0, 1, "R2 all banks");
    short_acc(0, REG_CTRL, 0, 1, 32'hFF, 0, 0, "R2 readback");
    // R4: mask off chip-assert bits
    short_acc(1, REG_CTRL, 32'hFF & ~32'hAA, 0, 0, 0, 1, "R4 deassert all");
    short_acc(0, REG_CTRL, 0, 1, 32'h55, 0, 0, "R4 enables kept");
    short_acc(1, REG_CTRL, 32'h00, 0, 0, 0, 1, "R4 write zero");
    short_acc(0, REG_CTRL, 0, 1, 32'h00, 0, 0, "R4 readback zero");
    short_acc(1, REG_CTRL, 32'h30, 0, 0, 0, 1, "R11 select bank2");

    // R5/R7: command, address and data cycles
    nand_write(20'h48000, 8'h90, 1, 0, "R5 R7 command cycle");
    nand_write(20'h30123, 8'h3C, 0, 1, "R5 R7 address cycle");
    nand_write(20'h00042, 8'hA5, 0, 0, "R5 R7 data cycle");
    nand_write(20'h07FFF, 8'h5A, 0, 0, "R5 data high offset");

    // R6: both offset bits -> refused
    short_acc(1, 20'h18000, 32'h77, 0, 0, 1, 0, "R6 write both bits");
    short_acc(0, 20'h38000, 0, 0, 0, 1, 0, "R6 read both bits");

    // R8: data read and refused reads
    nand_read(20'h20010, 8'h11, 8'hC3, "R8 data read capture");
    nand_read(20'h00000, 8'hEE, 8'h00, "R8 data read zero");
    short_acc(0, 20'h08000, 0, 0, 0, 1, 0, "R8 read in command window");
    short_acc(0, 20'h10000, 0, 0, 0, 1, 0, "R8 read in address window");

    // R9: synchroniser delay and ignored writes
    short_acc(0, REG_STAT, 0, 1, 32'h0, 0, 0, "R9 busy");
    nd_rb = 1;
    short_acc(0, REG_STAT, 0, 1, 32'h0, 0, 0, "R9 still old value");
    short_acc(0, REG_STAT, 0, 1, 32'h1, 0, 0, "R9 ready seen");
    short_acc(1, REG_STAT, 32'hFFFF_FFFF, 0, 0, 0, 0, "R9 status write");
    short_acc(0, REG_CTRL, 0, 1, 32'h30, 0, 0, "R9 ctrl untouched");
    short_acc(0, REG_STAT, 0, 1, 32'h1, 0, 0, "R9 status unchanged");

    // R10: back-to-back accesses, stalled until each finishes
    nand_write(20'h08000, 8'h00, 1, 0, "R10 first of pair");
    nand_read(20'h00004, 8'h0F, 8'h96, "R10 second of pair");
    for (int i = 0; i < 3; i++) step("R12 idle");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule